// File: doc/BRIEF.md
# DMA Source Address Generator

This block holds and advances the source address of a single DMA channel. Each completed transfer moves the address according to a two-bit update mode: hold it, step it up, or step it down. The step is one for a byte transfer and two for a word transfer. When the source is an external requesting device in single-address operation, the address is held whatever the mode says.

An optional repeat window confines the address to an aligned region of 2^N bytes. N comes from a four-bit size field. Only the low N address bits move, and the bits above them stay frozen. When the low bits roll over, the address wraps inside the window. If the repeat interrupt is also armed, the channel is stopped and an interrupt flag is raised.

In block mode the stop waits for the block-end strobe, so a block is never cut short. Software clears the flag and sets the channel active again to resume from the exact address where the channel stopped.

Top module: `src_addr_gen`

## Requirements
- R1: After reset the address is 0, the channel is inactive, the flag is clear and no interrupt is requested.
- R2: With `upd_mode` equal to 00 or 01 (fixed), a transfer leaves the address unchanged.
- R3: With `upd_mode` = 10, an active transfer adds 1 (byte, `word_sz`=0) or 2 (word, `word_sz`=1) to the address, visible after the next clock edge.
- R4: With `upd_mode` = 11, an active transfer subtracts 1 (byte) or 2 (word) from the address, visible after the next clock edge.
- R5: While `src_is_dev` is 1, transfers leave the address unchanged in every mode.
- R6: While `rpt_en` is 1, a transfer changes only address bits below `rpt_size`. The low bits wrap from all-ones to zero when stepping up, and from zero to all-ones when stepping down.
- R7: When `blk_mode` is 0 and a transfer overflows the window while `rpt_en` and `rpt_irq_en` are both 1, the next edge sets `irq_flag` and clears `active`.
- R8: When `blk_mode` is 1, an overflow does not stop the channel at once. The stop and the flag come with the first `blk_end` strobe at or after the overflow, while the channel is active and the repeat interrupt is armed.
- R9: `irq` is 1 exactly when `irq_flag` and `irq_en` are both 1.
- R10: Transfers while inactive leave the address unchanged. After `act_set`, stepping continues from the held address.
- R11: When `rpt_en` is 0, `rpt_irq_en` has no effect: no wrap, no stop and no flag.
- R12: `flag_clr` clears `irq_flag` on the next edge. A stop in the same cycle takes priority over the clear. A stop also takes priority over `act_set`.
- R13: `addr_load` writes `addr_in` to the address on the next edge, overriding any step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_load | input | 1 | Load strobe for the address |
| addr_in | input | AW | Address value to load |
| act_set | input | 1 | Start or resume strobe; sets the channel active |
| flag_clr | input | 1 | Clears the interrupt flag |
| upd_mode | input | 2 | 0x fixed, 10 step up, 11 step down |
| word_sz | input | 1 | 1 selects word (step 2), 0 selects byte (step 1) |
| src_is_dev | input | 1 | Source is an external requesting device in single-address operation |
| rpt_en | input | 1 | Repeat window configured |
| rpt_size | input | SW | Window exponent N (window of 2^N bytes) |
| rpt_irq_en | input | 1 | Stop and flag on window overflow |
| irq_en | input | 1 | Channel interrupt enable |
| blk_mode | input | 1 | Block transfer mode |
| xfer_done | input | 1 | One transfer completed |
| blk_end | input | 1 | Block-size transfer completed |
| addr | output | AW | Current source address |
| active | output | 1 | Channel active |
| irq_flag | output | 1 | Repeat-overflow interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
Wrong internal state shows at the ports within one clock edge. A bad step or a bad wrap appears on `addr` after the edge that follows the transfer. A lost or spurious stop appears on `active` and `irq_flag` at that same edge.

The deferred stop in block mode is the one piece of state that stays hidden. A wrongly kept or wrongly dropped pending overflow shows only at the next `blk_end`, so the stimulus places block ends several transfers after overflows, and also on the overflowing transfer itself.

// File: rtl/src_addr_gen.sv
module src_addr_gen #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          act_set,
  input  logic          flag_clr,
  input  logic [1:0]    upd_mode,
  input  logic          word_sz,
  input  logic          src_is_dev,
  input  logic          rpt_en,
  input  logic [SW-1:0] rpt_size,
  input  logic          rpt_irq_en,
  input  logic          irq_en,
  input  logic          blk_mode,
  input  logic          xfer_done,
  input  logic          blk_end,
  output logic [AW-1:0] addr,
  output logic          active,
  output logic          irq_flag,
  output logic          irq
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          pend;
  logic [AW-1:0] step, win_mask, raw, nxt;
  logic          upd, ovf, arm, stop;

  assign step     = word_sz ? (ONE << 1) : ONE;
  assign win_mask = (ONE << rpt_size) - ONE;
  assign upd      = xfer_done & active & ~src_is_dev & upd_mode[1] & ~addr_load;
  assign raw      = upd_mode[0] ? addr - step : addr + step;
  assign nxt      = rpt_en ? ((addr & ~win_mask) | (raw & win_mask)) : raw;
  assign ovf      = upd & rpt_en & ((raw & ~win_mask) != (addr & ~win_mask));
  assign arm      = rpt_en & rpt_irq_en;
  assign stop     = arm & ((ovf & ~blk_mode) |
                           (blk_mode & active & blk_end & (pend | ovf)));
  assign irq      = irq_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr     <= '0;
      active   <= 1'b0;
      irq_flag <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (addr_load)  addr <= addr_in;
      else if (upd)   addr <= nxt;

      if (stop)         active <= 1'b0;
      else if (act_set) active <= 1'b1;

      if (stop)          irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;

      if (stop)                           pend <= 1'b0;
      else if (ovf & arm & blk_mode)      pend <= 1'b1;
    end
  end
endmodule

module src_addr_gen_chk #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_load,
  input logic [1:0]    upd_mode,
  input logic          src_is_dev,
  input logic          rpt_en,
  input logic [SW-1:0] rpt_size,
  input logic          rpt_irq_en,
  input logic          blk_mode,
  input logic          blk_end,
  input logic          flag_clr,
  input logic [AW-1:0] addr,
  input logic          active,
  input logic          irq_flag
);
  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load && !upd_mode[1] |=> $stable(addr));
  assert_dev_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load && src_is_dev |=> $stable(addr));
  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_en && !addr_load |=> (addr >> $past(rpt_size)) == ($past(addr) >> $past(rpt_size)));
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> !active);
  assert_blk_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_mode && !blk_end |=> !$rose(irq_flag));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load && !active |=> $stable(addr));
  assert_no_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rpt_en && rpt_irq_en) |=> !$rose(irq_flag));
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !active |=> !irq_flag);
endmodule

bind src_addr_gen src_addr_gen_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .upd_mode(upd_mode),
  .src_is_dev(src_is_dev), .rpt_en(rpt_en), .rpt_size(rpt_size),
  .rpt_irq_en(rpt_irq_en), .blk_mode(blk_mode), .blk_end(blk_end),
  .flag_clr(flag_clr), .addr(addr), .active(active), .irq_flag(irq_flag)
);

// File: tb/src_addr_gen_tb.sv
module src_addr_gen_tb;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_load = 0, act_set = 0, flag_clr = 0, word_sz = 0, src_is_dev = 0;
  logic rpt_en = 0, rpt_irq_en = 0, irq_en = 0, blk_mode = 0, xfer_done = 0, blk_end = 0;
  logic [1:0] upd_mode = 2'b00;
  logic [SW-1:0] rpt_size = '0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr;
  logic active, irq_flag, irq;

  int total = 0, bad = 0;
  logic [AW-1:0] m_addr = '0;
  logic m_act = 0, m_flag = 0, m_pend = 0;

  always #(CLK_NS/2) clk = ~clk;

  src_addr_gen #(.AW(AW), .SW(SW)) u_dut (.*);

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] win_low(input logic [AW-1:0] a);
    longint unsigned sz = 64'd1 << rpt_size;
    return AW'(a % sz);
  endfunction

  task automatic predict();
    longint unsigned sz = 64'd1 << rpt_size;
    longint unsigned st = word_sz ? 2 : 1;
    longint unsigned lo = win_low(m_addr);
    logic mv = xfer_done && m_act && !src_is_dev && upd_mode[1] && !addr_load;
    logic ov = 0, stp;
    logic [AW-1:0] na = m_addr;
    if (mv) begin
      if (!rpt_en) na = upd_mode[0] ? m_addr - AW'(st) : m_addr + AW'(st);
      else if (!upd_mode[0]) begin
        ov = (lo + st) >= sz;
        na = m_addr - AW'(lo) + AW'((lo + st) % sz);
      end else begin
        ov = lo < st;
        na = m_addr - AW'(lo) + AW'((lo + sz - st) % sz);
      end
    end
    if (addr_load) na = addr_in;
    stp = rpt_en && rpt_irq_en &&
          ((!blk_mode && ov) || (blk_mode && m_act && blk_end && (m_pend || ov)));
    m_pend = stp ? 1'b0 : (m_pend || (ov && rpt_en && rpt_irq_en && blk_mode));
    m_flag = stp ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    m_act  = stp ? 1'b0 : (act_set ? 1'b1 : m_act);
    m_addr = na;
  endtask

  task automatic tick(input string tag);
    predict();
    @(negedge clk);
    chk({tag, " model addr (R3 R4 R6)"}, addr, m_addr);
    chk({tag, " model active (R7 R8)"}, AW'(active), AW'(m_act));
    chk({tag, " model flag (R12)"}, AW'(irq_flag), AW'(m_flag));
    chk({tag, " irq (R9)"}, AW'(irq), AW'(m_flag & irq_en));
    addr_load = 0; act_set = 0; flag_clr = 0; xfer_done = 0; blk_end = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 addr", addr, '0);
    chk("R1 active", AW'(active), '0);
    chk("R1 flag", AW'(irq_flag), '0);
    chk("R1 irq", AW'(irq), '0);
    rst_n = 1;
    @(negedge clk);

    addr_load = 1; addr_in = 32'h100; tick("R13"); chk("R13 load", addr, 32'h100);
    act_set = 1; tick("R10"); chk("R10 act", AW'(active), 1);
    upd_mode = 2'b10; word_sz = 0; xfer_done = 1; tick("R3"); chk("R3 byte up", addr, 32'h101);
    word_sz = 1; xfer_done = 1; tick("R3"); chk("R3 word up", addr, 32'h103);
    upd_mode = 2'b11; xfer_done = 1; tick("R4"); chk("R4 word down", addr, 32'h101);
    word_sz = 0; xfer_done = 1; tick("R4"); chk("R4 byte down", addr, 32'h100);
    upd_mode = 2'b01; xfer_done = 1; tick("R2"); chk("R2 fixed", addr, 32'h100);
    upd_mode = 2'b10; src_is_dev = 1; xfer_done = 1; tick("R5"); chk("R5 dev hold", addr, 32'h100);
    src_is_dev = 0;

    rpt_en = 1; rpt_size = 4; rpt_irq_en = 1;
    addr_load = 1; addr_in = 32'h10E; tick("R13");
    xfer_done = 1; tick("R6"); chk("R6 in window", addr, 32'h10F);
    xfer_done = 1; tick("R7"); chk("R6 wrap up", addr, 32'h100);
    chk("R7 flag", AW'(irq_flag), 1); chk("R7 stopped", AW'(active), 0);
    irq_en = 1; #1 chk("R9 irq on", AW'(irq), 1);
    irq_en = 0; #1 chk("R9 irq off", AW'(irq), 0);
    xfer_done = 1; tick("R10"); chk("R10 idle hold", addr, 32'h100);
    flag_clr = 1; tick("R12"); chk("R12 clear", AW'(irq_flag), 0);
    act_set = 1; tick("R10");
    upd_mode = 2'b11; xfer_done = 1; tick("R6"); chk("R6 wrap down", addr, 32'h10F);
    chk("R7 flag down", AW'(irq_flag), 1);
    flag_clr = 1; act_set = 1; tick("R12");

    blk_mode = 1; upd_mode = 2'b10;
    xfer_done = 1; tick("R8"); chk("R8 wrap", addr, 32'h100);
    chk("R8 no early flag", AW'(irq_flag), 0); chk("R8 still active", AW'(active), 1);
    xfer_done = 1; tick("R8"); chk("R8 keeps going", addr, 32'h101);
    xfer_done = 1; blk_end = 1; tick("R8"); chk("R8 addr", addr, 32'h102);
    chk("R8 flag at end", AW'(irq_flag), 1); chk("R8 stop at end", AW'(active), 0);
    flag_clr = 1; act_set = 1; tick("R10");
    xfer_done = 1; tick("R10"); chk("R10 resume", addr, 32'h103);

    blk_mode = 0; rpt_en = 0;
    addr_load = 1; addr_in = 32'h10F; tick("R11");
    xfer_done = 1; tick("R11"); chk("R11 no wrap", addr, 32'h110);
    chk("R11 no flag", AW'(irq_flag), 0); chk("R11 active", AW'(active), 1);

    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      xfer_done  = ($urandom % 4) != 0;
      blk_end    = ($urandom % 5) == 0;
      act_set    = ($urandom % 6) == 0;
      flag_clr   = ($urandom % 5) == 0;
      addr_load  = r < 3;
      addr_in    = $urandom;
      word_sz    = $urandom % 2;
      upd_mode   = 2'($urandom);
      src_is_dev = ($urandom % 10) == 0;
      rpt_size   = SW'($urandom % 6);
      if (r > 90) begin
        rpt_en = $urandom % 2; rpt_irq_en = $urandom % 2;
        blk_mode = $urandom % 2; irq_en = $urandom % 2;
      end
      tick("rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule